// File: doc/BRIEF.md
# Audio Sample Rate Generator

This block produces per-sample tick strobes for three audio converters: two playback channels and one capture channel. All timing comes from a reference clock-enable input that pulses at 1.4112 MHz inside the system clock domain. Each tick is a one-cycle strobe that tells a converter data path to move one sample frame.

The first playback channel takes one of four fixed rates. Each rate is a power-of-two division of the reference: 32, 64, 128 or 256 pulses per tick, which gives nominally 44100, 22050, 11025 and 5512 Hz. The capture channel has a programmable divider, N + 2 reference pulses per tick. The second playback channel picks one of three sources: the divider output it shares with capture, an external serial-audio tick strobe, or the first playback channel's ticks when the two playback channels must stay in lock-step. All settings come from a single control word. A new setting never cuts short a period that is already running.

Top module: `srg_rate_gen`

## Requirements
- R1: While reset is asserted, and until the first period completes after reset, all three tick outputs stay low, whatever ref_en does.
- R2: Control bits 13:12 pick the first playback period: value 3 gives 32 reference pulses per tick, 2 gives 64, 1 gives 128 and 0 gives 256.
- R3: Control bits 28:16 hold N (0 to 8191). The capture tick fires once every N + 2 reference pulses, so N = 30 gives 44100 Hz from 1.4112 MHz and N = 8191 gives the longest period, 8193.
- R4: The second playback source follows a fixed priority. With control bit 11 set it ticks in the same cycle as the first playback channel. Otherwise, with control bit 14 set, it ticks one cycle after each ext_tick strobe. Otherwise it ticks in the same cycle as the capture channel.
- R5: A period length is taken from the control word at the first reference pulse of that period. A change made in the middle of a period lets that period finish at its old length, and the next period uses the new length.
- R6: A change of the second playback source takes effect only after the source in use delivers its next tick, and that tick is still passed on. Before the first tick of that channel after reset, the channel follows the requested source directly.
- R7: A divided tick appears in the clock cycle after the reference pulse that completes its period. No divided tick fires without reference pulses.
- R8: Control bits outside 28:16, 14, 13:12 and 11 have no effect on any tick output.
- R9: The first playback and capture ticks are never high in two consecutive cycles, even at the shortest capture period of 2.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ref_en | input | 1 | Reference clock enable, one pulse per 1.4112 MHz period |
| ctrl_word | input | 32 | Control word holding the rate select, divider, sync and source bits |
| ext_tick | input | 1 | External serial-audio tick strobe, synchronous to clk |
| tick_play0 | output | 1 | First playback channel tick strobe |
| tick_play1 | output | 1 | Second playback channel tick strobe |
| tick_rec | output | 1 | Capture channel tick strobe |

## Verification
The hardest case to reach is a source switch on the second playback channel while a divider period is partly done. The switch must hold back the new source's ticks until the old source finishes its period. The fallback that follows the request before the first tick after reset must not hide this. The stimulus first lets the divider complete one whole period, so the channel is past that fallback. It then asks for lock-step mode a few pulses into the next divider period. Under the rule, the channel then gives one more full divider period followed by a short gap that ends on the first lock-step tick. The bench checks both of those periods.

// File: rtl/srg_pkg.sv
package srg_pkg;

   // Source of the second playback tick stream.
   typedef enum logic [1:0] {
      SRC_DIV  = 2'd0,
      SRC_EXT  = 2'd1,
      SRC_SYNC = 2'd2
   } pb1_src_e;

   // Lock-step request outranks the external strobe request.
   function automatic pb1_src_e pick_src(input logic sync_req, input logic ext_req);
      pb1_src_e s;
      if (sync_req)     s = SRC_SYNC;
      else if (ext_req) s = SRC_EXT;
      else              s = SRC_DIV;
      return s;
   endfunction

endpackage

// File: rtl/srg_period_ctr.sv
// Counts reference pulses. The terminal value is captured while the counter
// sits at zero, so a period always runs to the length sampled at its start.
module srg_period_ctr #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic [CNT_W-1:0] term_in,
   output logic             tick_o
);
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] term_q;
   logic             at_start;
   logic             at_end;

   assign at_start = (cnt_q == '0);
   assign at_end   = (cnt_q == term_q);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q  <= '0;
         term_q <= '1;
         tick_o <= 1'b0;
      end else begin
         if (at_start) begin
            term_q <= term_in;
         end
         tick_o <= ref_en && at_end;
         if (ref_en) begin
            cnt_q <= at_end ? '0 : cnt_q + ONE;
         end
      end
   end
endmodule

// File: rtl/srg_fixed_path.sv
// Fixed-rate path: the period is a power of two, longest at select 0.
module srg_fixed_path #(
   parameter int SEL_W     = 2,
   parameter int MIN_SHIFT = 5
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic [SEL_W-1:0] sel,
   output logic             tick_o
);
   localparam int NUM_RATES = 1 << SEL_W;
   localparam int CNT_W     = MIN_SHIFT + NUM_RATES - 1;

   logic [CNT_W-1:0] term_tab [NUM_RATES];
   logic [CNT_W-1:0] term_sel;

   for (genvar i = 0; i < NUM_RATES; i++) begin : g_term
      assign term_tab[i] = CNT_W'((64'd1 << (MIN_SHIFT + NUM_RATES - 1 - i)) - 64'd1);
   end

   assign term_sel = term_tab[sel];

   srg_period_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_en  (ref_en),
      .term_in (term_sel),
      .tick_o  (tick_o)
   );
endmodule

// File: rtl/srg_prog_path.sv
// Programmable path: period of N + 2 reference pulses.
module srg_prog_path #(
   parameter int DIV_W = 13
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             ref_en,
   input  logic [DIV_W-1:0] div_n,
   output logic             tick_o
);
   localparam int CNT_W = DIV_W + 1;
   localparam logic [CNT_W-1:0] ONE = {{(CNT_W-1){1'b0}}, 1'b1};

   logic [CNT_W-1:0] term_n;

   assign term_n = {1'b0, div_n} + ONE;

   srg_period_ctr #(.CNT_W(CNT_W)) i_ctr (
      .clk     (clk),
      .rst_n   (rst_n),
      .ref_en  (ref_en),
      .term_in (term_n),
      .tick_o  (tick_o)
   );
endmodule

// File: rtl/srg_pb1_select.sv
// Source mux for the second playback channel. The selection moves only when
// the current source ticks, or freely before the first tick after reset.
module srg_pb1_select
   import srg_pkg::*;
#(
   parameter int EXT_REG = 1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic sync_req,
   input  logic ext_req,
   input  logic fix_tick,
   input  logic div_tick,
   input  logic ext_tick,
   output logic tick_o
);
   logic     ext_src;
   logic     fresh_q;
   pb1_src_e src_q;
   pb1_src_e src_req;

   if (EXT_REG != 0) begin : g_ext_reg
      logic ext_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) ext_q <= 1'b0;
         else        ext_q <= ext_tick;
      end
      assign ext_src = ext_q;
   end else begin : g_ext_direct
      assign ext_src = ext_tick;
   end

   assign src_req = pick_src(sync_req, ext_req);

   always_comb begin
      unique case (src_q)
         SRC_SYNC: tick_o = fix_tick;
         SRC_EXT:  tick_o = ext_src;
         default:  tick_o = div_tick;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         fresh_q <= 1'b1;
         src_q   <= SRC_DIV;
      end else if (fresh_q || tick_o) begin
         src_q <= src_req;
         if (tick_o) begin
            fresh_q <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/srg_rate_gen.sv
module srg_rate_gen #(
   parameter int CTRL_W        = 32,
   parameter int RATE_SEL_LSB  = 12,
   parameter int RATE_SEL_W    = 2,
   parameter int FIX_MIN_SHIFT = 5,
   parameter int DIV_LSB       = 16,
   parameter int DIV_W         = 13,
   parameter int SYNC_BIT      = 11,
   parameter int EXT_SEL_BIT   = 14,
   parameter int EXT_REG       = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              ref_en,
   input  logic [CTRL_W-1:0] ctrl_word,
   input  logic              ext_tick,
   output logic              tick_play0,
   output logic              tick_play1,
   output logic              tick_rec
);
   localparam int FIX_CNT_W = FIX_MIN_SHIFT + (1 << RATE_SEL_W) - 1;

   // Elaboration-time parameter checks.
   if (RATE_SEL_LSB + RATE_SEL_W > CTRL_W) begin : g_bad_sel
      $error("rate select field exceeds control word");
   end
   if (DIV_LSB + DIV_W > CTRL_W) begin : g_bad_div
      $error("divider field exceeds control word");
   end
   if (SYNC_BIT >= CTRL_W || EXT_SEL_BIT >= CTRL_W) begin : g_bad_bit
      $error("select bit outside control word");
   end
   if (FIX_MIN_SHIFT < 1 || FIX_CNT_W > 30) begin : g_bad_fix
      $error("fixed period range unsupported");
   end
   if (DIV_W < 1 || DIV_W > 30) begin : g_bad_divw
      $error("divider width unsupported");
   end

   logic [RATE_SEL_W-1:0] rate_sel;
   logic [DIV_W-1:0]      div_n;
   logic                  sync_req;
   logic                  ext_req;
   logic                  fix_tick;
   logic                  div_tick;
   logic                  ctrl_unused;

   assign rate_sel    = ctrl_word[RATE_SEL_LSB +: RATE_SEL_W];
   assign div_n       = ctrl_word[DIV_LSB +: DIV_W];
   assign sync_req    = ctrl_word[SYNC_BIT];
   assign ext_req     = ctrl_word[EXT_SEL_BIT];
   assign ctrl_unused = ^ctrl_word;

   srg_fixed_path #(
      .SEL_W     (RATE_SEL_W),
      .MIN_SHIFT (FIX_MIN_SHIFT)
   ) i_fixed (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_en (ref_en),
      .sel    (rate_sel),
      .tick_o (fix_tick)
   );

   srg_prog_path #(.DIV_W(DIV_W)) i_prog (
      .clk    (clk),
      .rst_n  (rst_n),
      .ref_en (ref_en),
      .div_n  (div_n),
      .tick_o (div_tick)
   );

   srg_pb1_select #(.EXT_REG(EXT_REG)) i_pb1 (
      .clk      (clk),
      .rst_n    (rst_n),
      .sync_req (sync_req),
      .ext_req  (ext_req),
      .fix_tick (fix_tick),
      .div_tick (div_tick),
      .ext_tick (ext_tick),
      .tick_o   (tick_play1)
   );

   assign tick_play0 = fix_tick;
   assign tick_rec   = div_tick;
endmodule

// File: rtl/srg_rate_gen_chk.sv
module srg_rate_gen_chk #(
   parameter int RATE_SEL_W    = 2,
   parameter int FIX_MIN_SHIFT = 5,
   parameter int DIV_W         = 13,
   parameter int EXT_REG       = 1
) (
   input logic clk,
   input logic rst_n,
   input logic ref_en,
   input logic ext_tick,
   input logic tick_play0,
   input logic tick_play1,
   input logic tick_rec
);
   localparam int NUM_RATES = 1 << RATE_SEL_W;
   localparam logic [31:0] DIV_MAX_PER = (32'd1 << DIV_W) + 32'd1;

   logic [31:0] refs_fix;
   logic [31:0] refs_div;
   logic        ext_q;
   logic        ext_seen;

   function automatic logic fix_len_ok(input logic [31:0] n);
      for (int k = 0; k < NUM_RATES; k++) begin
         if (n == (32'd1 << (FIX_MIN_SHIFT + k))) return 1'b1;
      end
      return 1'b0;
   endfunction

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         refs_fix <= '0;
         refs_div <= '0;
         ext_q    <= 1'b0;
      end else begin
         ext_q <= ext_tick;
         if (tick_play0)  refs_fix <= {31'd0, ref_en};
         else if (ref_en) refs_fix <= refs_fix + 32'd1;
         if (tick_rec)    refs_div <= {31'd0, ref_en};
         else if (ref_en) refs_div <= refs_div + 32'd1;
      end
   end

   assign ext_seen = (EXT_REG != 0) ? ext_q : ext_tick;

   AST_FIX_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      tick_play0 |-> fix_len_ok(refs_fix));                                  // R2
   AST_DIV_PERIOD_LEN: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rec |-> (refs_div >= 32'd2 && refs_div <= DIV_MAX_PER));          // R3
   AST_PLAY1_HAS_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_play1 |-> (tick_play0 || tick_rec || ext_seen));                  // R4
   AST_PLAY0_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
      tick_play0 |-> $past(ref_en));                                         // R7
   AST_REC_AFTER_REF: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rec |-> $past(ref_en));                                           // R7
   AST_PLAY0_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_play0 |=> !tick_play0);                                           // R9
   AST_REC_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
      tick_rec |=> !tick_rec);                                               // R9
endmodule

bind srg_rate_gen srg_rate_gen_chk #(
   .RATE_SEL_W    (RATE_SEL_W),
   .FIX_MIN_SHIFT (FIX_MIN_SHIFT),
   .DIV_W         (DIV_W),
   .EXT_REG       (EXT_REG)
) i_srg_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .ref_en     (ref_en),
   .ext_tick   (ext_tick),
   .tick_play0 (tick_play0),
   .tick_play1 (tick_play1),
   .tick_rec   (tick_rec)
);

// File: tb/test_srg_rate_gen.sv
module test_srg_rate_gen;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        ref_en = 1'b0;
   logic        ext_tick = 1'b0;
   logic [31:0] ctrl_word = '0;
   logic        tick_play0, tick_play1, tick_rec;

   int n_chk = 0;
   int n_err = 0;
   bit done = 1'b0;

   // per-channel bookkeeping: 0 = play0, 1 = play1, 2 = rec
   int refs [3];
   int nt   [3];
   int per  [3][4];
   int mis01, mis1r, dbl0, dblr;
   bit prev0, prevr;

   always #4 clk = ~clk;

   srg_rate_gen i_srg_rate_gen (
      .clk        (clk),
      .rst_n      (rst_n),
      .ref_en     (ref_en),
      .ctrl_word  (ctrl_word),
      .ext_tick   (ext_tick),
      .tick_play0 (tick_play0),
      .tick_play1 (tick_play1),
      .tick_rec   (tick_rec)
   );

   // Control word layout: sel 13:12, N 28:16, lock-step 11, external 14.
   function automatic logic [31:0] mk_ctrl(input int sel, input int n,
                                           input bit sync, input bit ext);
      logic [31:0] w = '0;
      w[13:12] = sel[1:0];
      w[28:16] = n[12:0];
      w[11]    = sync;
      w[14]    = ext;
      return w;
   endfunction

   task automatic chk(input string req, input int got, input int exp);
      n_chk++;
      if (got != exp) begin
         n_err++;
         $display("FAIL %s: got %0d expected %0d", req, got, exp);
      end
   endtask

   task automatic clear_stats();
      for (int c = 0; c < 3; c++) begin
         refs[c] = 0;
         nt[c] = 0;
         for (int k = 0; k < 4; k++) per[c][k] = 0;
      end
      mis01 = 0; mis1r = 0; dbl0 = 0; dblr = 0;
      prev0 = 1'b0; prevr = 1'b0;
   endtask

   // Drive one cycle from a falling edge, sample at the next falling edge.
   task automatic step(input bit r, input bit e);
      bit t [3];
      ref_en   = r;
      ext_tick = e;
      @(negedge clk);
      t[0] = tick_play0; t[1] = tick_play1; t[2] = tick_rec;
      for (int c = 0; c < 3; c++) begin
         if (r) refs[c]++;
         if (t[c]) begin
            if (nt[c] < 4) per[c][nt[c]] = refs[c];
            nt[c]++;
            refs[c] = 0;
         end
      end
      if (t[0] != t[1]) mis01++;
      if (t[1] != t[2]) mis1r++;
      if (t[0] && prev0) dbl0++;
      if (t[2] && prevr) dblr++;
      prev0 = t[0]; prevr = t[2];
      ref_en = 1'b0; ext_tick = 1'b0;
   endtask

   task automatic do_reset(input logic [31:0] w);
      @(negedge clk);
      rst_n = 1'b0;
      ctrl_word = w;
      ref_en = 1'b1;
      for (int i = 0; i < 4; i++) @(negedge clk);
      ref_en = 1'b0;
      rst_n = 1'b1;
      clear_stats();
   endtask

   task automatic run_refs(input int n);
      for (int i = 0; i < n; i++) step(1'b1, 1'b0);
   endtask

   task automatic t_reset();
      int seen = 0;
      @(negedge clk);
      rst_n = 1'b0;
      ctrl_word = mk_ctrl(3, 0, 1'b0, 1'b0);
      ref_en = 1'b1;
      for (int i = 0; i < 40; i++) begin
         @(negedge clk);
         if (tick_play0 || tick_play1 || tick_rec) seen++;
      end
      chk("R1 ticks during reset", seen, 0);
      ref_en = 1'b0;
      rst_n = 1'b1;
      clear_stats();
      for (int i = 0; i < 300; i++) step(1'b0, 1'b0);
      chk("R7 play0 without ref", nt[0], 0);
      chk("R7 rec without ref", nt[2], 0);
      chk("R1 play1 idle after reset", nt[1], 0);
   endtask

   task automatic t_fixed(input int sel);
      int exp = 256 >> sel;
      do_reset(mk_ctrl(sel, 100, 1'b0, 1'b0));
      run_refs(2 * exp + 2);
      chk($sformatf("R2 sel %0d first period", sel), per[0][0], exp);
      chk($sformatf("R2 sel %0d second period", sel), per[0][1], exp);
   endtask

   task automatic t_div(input int n);
      do_reset(mk_ctrl(0, n, 1'b0, 1'b0));
      run_refs(2 * (n + 2) + 1);
      chk($sformatf("R3 N=%0d first period", n), per[2][0], n + 2);
      chk($sformatf("R3 N=%0d second period", n), per[2][1], n + 2);
      chk($sformatf("R4 N=%0d play1 follows rec", n), mis1r, 0);
      chk($sformatf("R9 N=%0d rec double", n), dblr, 0);
      chk($sformatf("R9 N=%0d play0 double", n), dbl0, 0);
   endtask

   task automatic t_sync();
      // lock-step outranks the external request; also exercises R6 fallback
      do_reset(mk_ctrl(2, 10, 1'b1, 1'b1));
      run_refs(200);
      chk("R4 R6 play1 locked to play0", mis01, 0);
      chk("R4 play1 tick count", nt[1], 3);
   endtask

   task automatic t_ext();
      int bad = 0;
      do_reset(mk_ctrl(3, 4, 1'b0, 1'b1));
      for (int i = 0; i < 100; i++) begin
         bit e = (i % 20 == 10);
         step(1'b1, e);
         if (tick_play1 != e) bad++;
      end
      chk("R4 external strobe timing", bad, 0);
      chk("R4 external tick count", nt[1], 5);
      chk("R4 rec unaffected by external", nt[2], 16);
   endtask

   task automatic t_midchange();
      do_reset(mk_ctrl(3, 30, 1'b0, 1'b0));
      run_refs(10);
      ctrl_word = mk_ctrl(0, 8, 1'b0, 1'b0);
      run_refs(32 + 256 - 10 + 2);
      chk("R5 fixed old period kept", per[0][0], 32);
      chk("R5 fixed new period", per[0][1], 256);
      chk("R5 divider old period kept", per[2][0], 32);
      chk("R5 divider new period", per[2][1], 10);
   endtask

   task automatic t_switch();
      do_reset(mk_ctrl(3, 98, 1'b0, 1'b0));
      run_refs(105);
      ctrl_word = mk_ctrl(3, 98, 1'b1, 1'b0);
      run_refs(125);
      chk("R6 play1 first period", per[1][0], 100);
      chk("R6 play1 holds divider period", per[1][1], 100);
      chk("R6 play1 joins play0", per[1][2], 24);
   endtask

   task automatic t_ignored();
      logic [31:0] junk = 32'hE000_87FF;
      do_reset(mk_ctrl(1, 20, 1'b0, 1'b0) | junk);
      run_refs(100);
      ctrl_word = mk_ctrl(1, 20, 1'b0, 1'b0);
      run_refs(60);
      ctrl_word = mk_ctrl(1, 20, 1'b0, 1'b0) | 32'hA000_8555;
      run_refs(110);
      chk("R8 play0 period", per[0][1], 128);
      chk("R8 rec period", per[2][3], 22);
      chk("R8 play1 source", mis1r, 0);
   endtask

   initial begin
      #(8 * 200000);
      if (!done) begin
         n_err++;
         n_chk++;
         $display("FAIL watchdog: got timeout expected completion");
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      clear_stats();
      t_reset();
      for (int s = 0; s < 4; s++) t_fixed(s);
      t_div(0);
      t_div(5);
      t_div(30);
      t_div(8191);
      t_sync();
      t_ext();
      t_midchange();
      t_switch();
      t_ignored();
      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule